// File: doc/BRIEF.md
# Shared-Bus Grant Arbiter with Unresponsive-Master Lockout

This block decides which of eight bus masters may drive a shared PCI-style bus next. Master 0 is the bridge's own master. Masters 1 to 7 sit outside the chip. Masters 5, 6 and 7 take part only when their enable inputs are set. Each master has a one-bit priority. A high-priority requester always wins over a low-priority one. Within a level, masters are served in rotation, starting from the master after the last one granted.

The arbiter supervises every grant it hands out. Suppose the owner keeps requesting and the bus stays idle (no FRAME, no IRDY) for 16 consecutive clocks. The arbiter then records that master as unresponsive in a sticky status vector and stops considering it. A one-cycle clear pulse from software returns the master to arbitration.

When nobody is requesting, the grant can be parked on a selected master. Request and grant are active high here, so pin polarity is converted outside the block.

Top module: `pci_bus_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `gnt` and `dead` both become all zero. After reset, the rotation search starts at master 0.
- R2: Masters 0 to 4 are always eligible. Master 5, 6 or 7 is eligible only while `ext_en[0]`, `ext_en[1]` or `ext_en[2]` respectively is 1. An ineligible master's request never yields a grant.
- R3: `prio[i]` = 1 puts master i in the high level. Any eligible high-level requester is granted ahead of every low-level requester.
- R4: Within the winning level, the grant goes to the first requester found by searching upward, with wrap-around, from the master after the last master granted on a request.
- R5: `gnt` is registered. It has at most one bit set, and it reflects the request pattern sampled at the preceding clock edge.
- R6: While the current owner keeps requesting and is still eligible, its grant is held, even if other masters, including high-priority ones, request. When the owner drops its request, the grant moves at the next edge.
- R7: If the owner requests while `frame_act` and `irdy_act` are both 0 at 16 consecutive edges after its grant, bit `dead[owner]` is 1 after the 16th such edge, and the grant is removed at the edge after that.
- R8: An edge at which `frame_act` or `irdy_act` is 1 restarts the 16-edge count, so a master that starts its transaction is never marked.
- R9: While `dead[i]` = 1, master i's request is ignored, and master i is never granted or parked on.
- R10: A 1 on `dead_clr[i]` at an edge clears `dead[i]`, and the master can be granted from the following edge. If a timeout sets the same bit at that edge, the set wins.
- R11: While `arb_en` is 0 at an edge, `gnt` is all zero after that edge.
- R12: With no eligible requester, `park_en` = 1 grants master `park_sel` (3-bit index), provided it is eligible under R2 and not dead. Otherwise `gnt` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arb_en | input | 1 | Arbitration enable |
| req | input | 8 | Request per master, active high |
| frame_act | input | 1 | FRAME asserted on the bus |
| irdy_act | input | 1 | IRDY asserted on the bus |
| ext_en | input | 3 | Join enables for masters 5, 6, 7 |
| prio | input | 8 | Priority level per master, 1 = high |
| park_en | input | 1 | Park the grant when idle |
| park_sel | input | 3 | Index of the parking master |
| dead_clr | input | 8 | Per-master clear pulse for the lockout bit |
| gnt | output | 8 | Grant per master, active high, one-hot or zero |
| dead | output | 8 | Sticky unresponsive-master flags |

## Verification
The hardest state to reach is the lockout and its release. The owner must keep requesting across exactly 16 idle edges and no fewer. The bench walks a lone requester through 15 edges, checks that the flag is still clear, then checks that it appears on the 16th and that the grant leaves one edge later. It then shows that the locked master is refused both as a requester and as a parking target. Finally, a clear pulse restores the grant one edge after the clear. A separate run holds FRAME for 20 edges and shows that no flag appears.

// File: rtl/pciarb_pkg.sv
// Package: shared sizing constants for the bus arbiter.
// Assumes at most 8 masters, so a 3-bit index is enough for the default.
package pciarb_pkg;
    localparam int PA_MASTERS   = 8;
    localparam int PA_IDXW      = $clog2(PA_MASTERS);
    localparam int PA_EXT_FIRST = 5;   // first master gated by an enable
    localparam int PA_TIMEOUT   = 16;  // idle edges before lockout
endpackage

// File: rtl/pciarb_rr_pick.sv
// Round-robin picker: returns the first set bit of mask found by searching
// upward from ptr+1 with wrap-around. Purely combinational.
// Assumes N >= 2.
module pciarb_rr_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] ptr,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Scan from the farthest offset down, so the nearest match is assigned last.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int off = N; off >= 1; off--) begin
            int cand;
            cand = (int'(ptr) + off) % N;
            if (mask[cand]) begin
                hit = 1'b1;
                idx = IW'(cand);
            end
        end
    end

    // Whenever a match is reported, the chosen bit must be set in the mask.
    always_comb begin
        if (hit) assert (mask[idx]) else $error("p_pick_valid_r4");
    end
endmodule

// File: rtl/pciarb_watchdog.sv
// Grant watchdog: counts consecutive edges at which cond holds, and raises
// fire during the cycle in which the LIMIT-th such edge will occur.
// Assumes the caller drops cond whenever ownership changes.
module pciarb_watchdog #(
    parameter int LIMIT = 16,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic fire
);
    logic [CW-1:0] cnt_q;

    assign fire = cond && (cnt_q == CW'(LIMIT - 1));

    // Count idle-owner edges, restarting on a break or after firing.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!cond || fire) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    p_cnt_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> cnt_q == '0);
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT));
endmodule

// File: rtl/pciarb_status.sv
// Sticky lockout flags: a set pulse marks a master dead, and a clear pulse
// revives it. A set beats a clear of the same bit in the same cycle.
module pciarb_status #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] dead_q
);
    // Update the flags: clear first, then apply new timeouts.
    always_ff @(posedge clk) begin
        if (!rst_n) dead_q <= '0;
        else        dead_q <= (dead_q & ~clr_vec) | set_vec;
    end

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(dead_q) & ~$past(clr_vec)) & ~dead_q) == '0));
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(set_vec) & ~dead_q) == '0));
endmodule

// File: rtl/pci_bus_arbiter.sv
// Central arbiter for a shared bus: two priority levels with round-robin
// inside each, no preemption of an owner that still requests, parking, and
// lockout of a master that sits on its grant without starting a cycle.
// Assumes request and bus-status inputs are synchronous to clk.
module pci_bus_arbiter
    import pciarb_pkg::*;
#(
    parameter int N         = PA_MASTERS,
    parameter int EXT_FIRST = PA_EXT_FIRST,
    parameter int TIMEOUT   = PA_TIMEOUT,
    parameter int IW        = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arb_en,
    input  logic [N-1:0]         req,
    input  logic                 frame_act,
    input  logic                 irdy_act,
    input  logic [N-EXT_FIRST-1:0] ext_en,
    input  logic [N-1:0]         prio,
    input  logic                 park_en,
    input  logic [IW-1:0]        park_sel,
    input  logic [N-1:0]         dead_clr,
    output logic [N-1:0]         gnt,
    output logic [N-1:0]         dead
);
    logic [N-1:0]  en_mask, elig, set_vec;
    logic [N-1:0]  lvl_mask [2];
    logic          lvl_hit  [2];
    logic [IW-1:0] lvl_idx  [2];
    logic [IW-1:0] owner_q, owner_d, ptr_q, ptr_d;
    logic          valid_q, valid_d, owner_live, wd_cond, wd_fire;

    // Per-master membership: fixed masters always in, the upper ones gated.
    for (genvar g = 0; g < N; g++) begin : g_en
        if (g >= EXT_FIRST) begin : g_ext
            assign en_mask[g] = ext_en[g - EXT_FIRST];
        end else begin : g_fix
            assign en_mask[g] = 1'b1;
        end
    end

    assign elig        = req & en_mask & ~dead & {N{arb_en}};
    assign lvl_mask[0] = elig & prio;
    assign lvl_mask[1] = elig & ~prio;
    assign owner_live  = valid_q && elig[owner_q];

    // One picker per priority level, sharing the rotation pointer.
    for (genvar l = 0; l < 2; l++) begin : g_lvl
        pciarb_rr_pick #(.N(N), .IW(IW)) pick_i (
            .mask (lvl_mask[l]),
            .ptr  (ptr_q),
            .hit  (lvl_hit[l]),
            .idx  (lvl_idx[l])
        );
    end

    // Next-owner decision: hold, then high, then low, then park.
    always_comb begin
        owner_d = owner_q;
        valid_d = valid_q;
        ptr_d   = ptr_q;
        if (!arb_en) begin
            valid_d = 1'b0;
        end else if (owner_live) begin
            valid_d = 1'b1;
        end else if (lvl_hit[0]) begin
            valid_d = 1'b1; owner_d = lvl_idx[0]; ptr_d = lvl_idx[0];
        end else if (lvl_hit[1]) begin
            valid_d = 1'b1; owner_d = lvl_idx[1]; ptr_d = lvl_idx[1];
        end else if (park_en && en_mask[park_sel] && !dead[park_sel]) begin
            valid_d = 1'b1; owner_d = park_sel;
        end else begin
            valid_d = 1'b0;
        end
    end

    // Register the grant owner and the rotation pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= '0;
            valid_q <= 1'b0;
            ptr_q   <= IW'(N - 1);
        end else begin
            owner_q <= owner_d;
            valid_q <= valid_d;
            ptr_q   <= ptr_d;
        end
    end

    assign gnt = valid_q ? (N'(1) << owner_q) : '0;

    // Watch the owner while it requests on an idle bus.
    assign wd_cond = owner_live && !frame_act && !irdy_act;

    pciarb_watchdog #(.LIMIT(TIMEOUT)) wd_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (wd_cond),
        .fire  (wd_fire)
    );

    assign set_vec = wd_fire ? (N'(1) << owner_q) : '0;

    pciarb_status #(.N(N)) stat_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (dead_clr),
        .dead_q  (dead)
    );

    p_one_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    p_disable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_en |=> gnt == '0);
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && elig[owner_q]) |=> gnt == $past(gnt));
    p_no_dead_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & $past(dead)) == '0);
    p_mark_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((dead & ~$past(dead)) & ~$past(gnt)) == '0);
endmodule

// File: tb/pci_bus_arbiter_tb_top.sv
// Bench: table-driven arbitration vectors, then directed reset, hold,
// timeout, lockout, clear, FRAME, disable and parking tests.
module pci_bus_arbiter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arb_en = 1'b1;
    logic [7:0] req = '0;
    logic       frame_act = 1'b0;
    logic       irdy_act = 1'b0;
    logic [2:0] ext_en = '0;
    logic [7:0] prio = '0;
    logic       park_en = 1'b0;
    logic [2:0] park_sel = '0;
    logic [7:0] dead_clr = '0;
    logic [7:0] gnt, dead;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pci_bus_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .arb_en(arb_en), .req(req),
        .frame_act(frame_act), .irdy_act(irdy_act), .ext_en(ext_en),
        .prio(prio), .park_en(park_en), .park_sel(park_sel),
        .dead_clr(dead_clr), .gnt(gnt), .dead(dead)
    );

    // Vector layout: {req[26:19], prio[18:11], ext_en[10:8], expected gnt[7:0]}
    localparam int NV = 11;
    localparam logic [26:0] VEC [NV] = '{
        {8'h01, 8'h00, 3'b000, 8'h01},  // R4 first search from master 0
        {8'h06, 8'h00, 3'b000, 8'h02},  // R4
        {8'h07, 8'h00, 3'b000, 8'h04},  // R4
        {8'h05, 8'h00, 3'b000, 8'h01},  // R4 wrap
        {8'h0F, 8'h08, 3'b000, 8'h08},  // R3
        {8'hE0, 8'h00, 3'b000, 8'h00},  // R2 all gated off
        {8'hE0, 8'h00, 3'b010, 8'h40},  // R2 only master 6 enabled
        {8'hF0, 8'h11, 3'b111, 8'h10},  // R3
        {8'h81, 8'h00, 3'b111, 8'h80},  // R4
        {8'h81, 8'h00, 3'b111, 8'h01},  // R4
        {8'hFF, 8'h80, 3'b000, 8'h02}   // R2 R3 high master gated off
    };

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        req = 8'hFF;
        step(); step();
        check("R1 gnt at reset", gnt, 8'h00);
        check("R1 dead at reset", dead, 8'h00);
        req = '0;
        rst_n = 1'b1;
        step();

        for (int v = 0; v < NV; v++) begin
            req    = VEC[v][26:19];
            prio   = VEC[v][18:11];
            ext_en = VEC[v][10:8];
            step();
            check($sformatf("R5 vector %0d", v), gnt, VEC[v][7:0]);
            req = '0;
            step();
            check("R5 released", gnt, 8'h00);
        end
        prio = '0; ext_en = '0;

        // R6: the owner keeps the grant while it requests.
        frame_act = 1'b1;
        req = 8'h02; step();
        check("R6 first owner", gnt, 8'h02);
        req = 8'h06; prio = 8'h04; step(); step(); step();
        check("R6 no preemption", gnt, 8'h02);
        req = 8'h04; step();
        check("R6 handover on drop", gnt, 8'h04);
        req = '0; prio = '0; frame_act = 1'b0; step();

        // R8: an active FRAME keeps the watchdog quiet.
        frame_act = 1'b1; req = 8'h08; step();
        for (int i = 0; i < 20; i++) step();
        check("R8 no lockout with FRAME", dead, 8'h00);
        check("R8 grant kept", gnt, 8'h08);
        req = '0; frame_act = 1'b0; step();

        // R7: master 2 sits on its grant with the bus idle.
        req = 8'h04; step();
        check("R7 grant issued", gnt, 8'h04);
        for (int i = 0; i < 15; i++) step();
        check("R7 not yet marked", dead, 8'h00);
        step();
        check("R7 marked on 16th edge", dead, 8'h04);
        check("R7 grant still up", gnt, 8'h04);
        step();
        check("R7 grant withdrawn", gnt, 8'h00);
        step(); step();
        check("R9 request ignored", gnt, 8'h00);

        // R12 and R9: no parking on a dead master, parking on a live one.
        park_en = 1'b1; park_sel = 3'd2; req = '0; step(); step();
        check("R12 R9 park refused on dead", gnt, 8'h00);
        park_sel = 3'd3; step();
        check("R12 park on master 3", gnt, 8'h08);
        park_sel = 3'd6; step();
        check("R12 R2 park refused on gated", gnt, 8'h00);
        park_en = 1'b0; step();

        // R10: clear master 2 and see it granted again.
        req = 8'h04; dead_clr = 8'h04; step();
        dead_clr = '0;
        check("R10 flag cleared", dead, 8'h00);
        check("R10 no grant on clear edge", gnt, 8'h00);
        step();
        check("R10 grant restored", gnt, 8'h04);
        req = '0; step();

        // R11: disable blocks every grant.
        arb_en = 1'b0; req = 8'h1F; step();
        check("R11 disabled", gnt, 8'h00);
        arb_en = 1'b1; step();
        check("R11 re-enabled", gnt, 8'h08);
        req = '0; step();
        check("R5 idle", gnt, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule